// File: doc/BRIEF.md
# Dual BT.656 stream interleaver

This block takes two BT.656 byte streams that already share one clock domain and merges them onto a single 8-bit bus clocked at twice their sample rate. Each input byte is presented for two fast-clock cycles. The block marks with `in_take` the fast cycle at whose closing edge it captures both inputs. A channel flag travels with every output byte, so a receiver further down can split the merged bus back into two streams.

Two modes are selected with `mode`, which is held constant outside reset. In pixel mode the output alternates one byte of channel 0 with one byte of channel 1. In line mode each channel's bytes pass through a 3-byte detection window into that channel's own line queue. Whole lines, each running from one end-of-active-video code up to the next, are then sent out one channel at a time. Line edges come from the timing reference codes in each stream, never from fixed blanking counts, so the two channels may differ in line and field phase. When the channel whose turn it is has no complete line stored, a short blanking filler goes out in its place, and the other channel is never held up.

Top module: `dual_bt656_interleaver`

## Requirements
- R1: While reset is asserted, `data_out` is 0x00, `ch_id` is 0 and `in_take` is 1.
- R2: `in_take` is 1 in the first fast cycle after reset and then toggles every fast cycle. `din0`/`din1` are captured at each clock edge that ends a cycle with `in_take` = 1.
- R3: In pixel mode (`mode` = 0), the edge that captures an input pair makes `data_out` equal the captured `din0` with `ch_id` = 0. The following edge makes `data_out` equal the captured `din1` with `ch_id` = 1.
- R4: In line mode (`mode` = 1), a line starts at the sequence 0xFF, 0x00, 0x00, XY with XY bit 7 = 1 and bit 4 = 1. A start-of-active-video code (XY bit 4 = 0) does not start a line. A channel's bytes before its first such sequence are discarded.
- R5: In line mode, a complete line goes out unaltered and contiguously, one byte per fast cycle, starting with its 0xFF byte, with `ch_id` fixed at that channel for the whole line.
- R6: In line mode, service slots alternate between the channels, starting with channel 0 after reset. `ch_id` changes only at a slot start, where `data_out` is 0xFF (a line) or 0x80 (a filler).
- R7: If the channel whose slot it is has no complete line stored, the block emits 0x80 and then 0x10 under that channel's `ch_id`, and the next slot goes to the other channel.
- R8: A line counts as complete only once that channel's next line-start sequence has been received. Each channel queue holds `DEPTH` bytes (a power of two) and is never written when full or read when empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the input sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 1 | 0 = pixel interleave, 1 = line interleave |
| din0 | input | 8 | Channel 0 BT.656 byte, held for two fast cycles |
| din1 | input | 8 | Channel 1 BT.656 byte, held for two fast cycles |
| in_take | output | 1 | High in the fast cycle whose closing edge captures the inputs |
| data_out | output | 8 | Merged output byte |
| ch_id | output | 1 | Channel that `data_out` belongs to |

## Verification
In line mode, a new byte can enter a channel queue, with its line-start flag set, in the same cycle that the reader pops that queue's previous line-start entry to begin a slot. The stored-line count then gains and loses one in a single edge. Running the two channels at a seven-byte phase offset makes this overlap happen repeatedly. The outcome is judged at the ports by rebuilding each channel's line stream from the output and comparing every byte with the bench's own copy of the input from that channel's first line start. A second line-mode run keeps channel 1 free of line starts, so its slots must become filler pairs while channel 0's lines still come out whole.

// File: rtl/dual_bt656_interleaver.sv
module dual_bt656_interleaver #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode,
  input  logic [7:0] din0,
  input  logic [7:0] din1,
  output logic       in_take,
  output logic [7:0] data_out,
  output logic       ch_id
);

  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic       phase, busy, fill2, sel, nxt_c;
  logic [7:0] hold1;
  logic [7:0] din_a [2];
  logic [7:0] pipe [2][3];
  logic [8:0] fifo [2][DEPTH];
  logic [8:0] head [2];
  logic [AW-1:0] wp [2], rp [2];
  logic [AW:0]   cnt [2], starts [2];
  logic [1:0] synced, eav, push, pop, ready;

  assign in_take  = ~phase;
  assign din_a[0] = din0;
  assign din_a[1] = din1;

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      eav[c]   = pipe[c][2] == 8'hFF && pipe[c][1] == 8'h00 && pipe[c][0] == 8'h00
                 && din_a[c][7] && din_a[c][4];
      push[c]  = mode && in_take && (synced[c] || eav[c]);
      head[c]  = fifo[c][rp[c]];
      ready[c] = starts[c] >= (AW+1)'(2);
    end
  end

  always_comb begin
    nxt_c = busy ? ~ch_id : sel;
    pop   = 2'b00;
    if (mode && !fill2) begin
      if (busy && !head[ch_id][8]) pop[ch_id] = 1'b1;
      else if (ready[nxt_c])       pop[nxt_c] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < 2; c++)
      if (push[c]) fifo[c][wp[c]] <= {eav[c], pipe[c][2]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      synced <= 2'b00;
      for (int c = 0; c < 2; c++) begin
        wp[c] <= '0;
        rp[c] <= '0;
        cnt[c] <= '0;
        starts[c] <= '0;
        for (int s = 0; s < 3; s++) pipe[c][s] <= 8'h00;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (mode && in_take) begin
          pipe[c][2] <= pipe[c][1];
          pipe[c][1] <= pipe[c][0];
          pipe[c][0] <= din_a[c];
        end
        if (push[c]) wp[c] <= wp[c] + 1'b1;
        if (pop[c])  rp[c] <= rp[c] + 1'b1;
        if (push[c] && eav[c]) synced[c] <= 1'b1;
        cnt[c]    <= cnt[c] + {{AW{1'b0}}, push[c]} - {{AW{1'b0}}, pop[c]};
        starts[c] <= starts[c] + {{AW{1'b0}}, push[c] & eav[c]}
                               - {{AW{1'b0}}, pop[c] & head[c][8]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= 1'b0;
      hold1    <= 8'h00;
      data_out <= 8'h00;
      ch_id    <= 1'b0;
      busy     <= 1'b0;
      fill2    <= 1'b0;
      sel      <= 1'b0;
    end else begin
      phase <= ~phase;
      if (!mode) begin
        if (in_take) begin
          data_out <= din0;
          hold1    <= din1;
          ch_id    <= 1'b0;
        end else begin
          data_out <= hold1;
          ch_id    <= 1'b1;
        end
      end else if (fill2) begin
        data_out <= 8'h10;
        fill2    <= 1'b0;
      end else if (busy && !head[ch_id][8]) begin
        data_out <= head[ch_id][7:0];
      end else if (ready[nxt_c]) begin
        data_out <= head[nxt_c][7:0];
        ch_id    <= nxt_c;
        busy     <= 1'b1;
      end else begin
        data_out <= 8'h80;
        ch_id    <= nxt_c;
        fill2    <= 1'b1;
        busy     <= 1'b0;
        sel      <= ~nxt_c;
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_q
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      push[g] |-> cnt[g] != FULL);
    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pop[g] |-> cnt[g] != '0);
  end

  assert_pixel_alternate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && !in_take) |=> ch_id);

  assert_id_at_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && ch_id != $past(ch_id)) |-> (data_out == 8'hFF || data_out == 8'h80));

  assert_filler_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && data_out == 8'h80 && ch_id != $past(ch_id)) |=> data_out == 8'h10);

  assert_line_contig_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && busy && !fill2 && !head[ch_id][8]) |=> ch_id == $past(ch_id));

endmodule

// File: tb/test_dual_bt656_interleaver.sv
`timescale 1ns/1ps
module test_dual_bt656_interleaver;

  logic clk = 1'b0, rst_n = 1'b0, mode = 1'b0;
  logic [7:0] din0 = 8'h00, din1 = 8'h00;
  logic in_take, ch_id;
  logic [7:0] data_out;
  int errors = 0, checks = 0;

  dual_bt656_interleaver i_dual_bt656_interleaver (
    .clk(clk), .rst_n(rst_n), .mode(mode), .din0(din0), .din1(din1),
    .in_take(in_take), .data_out(data_out), .ch_id(ch_id));

  always #10 clk = ~clk;

  localparam logic [15:0] PIX [8] = '{16'h1020, 16'hFF00, 16'h00FF, 16'h8010,
                                     16'hA55A, 16'h0102, 16'h7E81, 16'hC33C};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input int ch, input int i);
    int p = i % 20;
    int ln = i / 20;
    case (p)
      0, 8:   return 8'hFF;
      1, 2, 9, 10: return 8'h00;
      3:      return 8'h9D;
      11:     return 8'h80;
      4, 6:   return 8'h80;
      5, 7:   return 8'h10;
      default: return 8'(8'h20 + ch * 8'h30 + (ln * 3 + p) % 16);
    endcase
  endfunction

  function automatic logic [7:0] src1(input int k);
    return (k < 7) ? 8'h10 : gen(1, k - 7);
  endfunction

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst_n = 1'b0;
    mode  = m;
    @(negedge clk);
    chk(data_out == 8'h00 && ch_id == 1'b0 && in_take == 1'b1, "R1 reset state",
        {data_out, ch_id, in_take}, {8'h00, 1'b0, 1'b1});
    rst_n = 1'b1;
  endtask

  int rx [2], lines [2], fills [2];

  task automatic run_line(input bit silent, input int cycles);
    int k = 0;
    bit first = 1'b1, in_line = 1'b0, exp10 = 1'b0;
    logic prev_id = 1'b0;
    for (int c = 0; c < 2; c++) begin rx[c] = 0; lines[c] = 0; fills[c] = 0; end
    din0 = gen(0, 0);
    din1 = silent ? 8'h10 : src1(0);
    k = 1;
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      if (first) chk(data_out == 8'h80 && ch_id == 1'b0, "R8 filler before first complete line",
                     {data_out, ch_id}, {8'h80, 1'b0});
      if (first || ch_id != prev_id) begin
        if (data_out == 8'hFF) begin
          in_line = 1'b1;
          lines[ch_id]++;
        end else begin
          in_line = 1'b0;
          chk(data_out == 8'h80, "R6 slot start byte", data_out, 8'h80);
          exp10 = 1'b1;
          fills[ch_id]++;
        end
      end else if (exp10) begin
        chk(data_out == 8'h10, "R7 filler second byte", data_out, 8'h10);
        exp10 = 1'b0;
      end else if (!in_line) begin
        chk(1'b0, "R6 byte outside any slot", data_out, 0);
      end
      if (in_line) begin
        if (rx[ch_id] == 0)
          chk(data_out == gen(ch_id, 0), "R4 first line begins at first EAV",
              data_out, gen(ch_id, 0));
        else
          chk(data_out == gen(ch_id, rx[ch_id]), "R5 line byte", data_out, gen(ch_id, rx[ch_id]));
        rx[ch_id]++;
      end
      prev_id = ch_id;
      first = 1'b0;
      if (in_take) begin
        din0 = gen(0, k);
        din1 = silent ? 8'h10 : src1(k);
        k++;
      end
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL R5 watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    for (int v = 0; v < 8; v++) begin
      chk(in_take == 1'b1, "R2 capture phase", in_take, 1);
      din0 = PIX[v][15:8];
      din1 = PIX[v][7:0];
      @(negedge clk);
      chk(data_out == PIX[v][15:8] && ch_id == 1'b0, "R3 channel 0 byte",
          {data_out, ch_id}, {PIX[v][15:8], 1'b0});
      chk(in_take == 1'b0, "R2 in_take toggles", in_take, 0);
      din0 = 8'h55;
      din1 = 8'hAA;
      @(negedge clk);
      chk(data_out == PIX[v][7:0] && ch_id == 1'b1, "R3 channel 1 byte",
          {data_out, ch_id}, {PIX[v][7:0], 1'b1});
    end

    do_reset(1'b1);
    run_line(1'b0, 700);
    chk(lines[0] >= 3, "R6 channel 0 lines served", lines[0], 3);
    chk(lines[1] >= 3, "R6 channel 1 lines served", lines[1], 3);

    do_reset(1'b1);
    run_line(1'b1, 700);
    chk(lines[0] >= 3, "R7 channel 0 not stalled", lines[0], 3);
    chk(lines[1] == 0, "R7 silent channel sends no line", lines[1], 0);
    chk(fills[1] >= 3, "R7 silent channel slots filled", fills[1], 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule